// File: doc/BRIEF.md
# UART Interrupt Status and Mask Unit

This block sits beside the FIFOs of a UART and turns their state into interrupt information. From the receive and transmit occupancy counts and two programmable trigger levels it forms a live status word: empty, full and trigger-level flags for each direction. The live word is read-only and follows its inputs in the same cycle.

A sticky status register collects events. The five low live flags and the transmit trigger flag are folded into it on every clock edge. One-cycle pulses from the serial logic also set it: receive overrun, framing error, parity error, receive timeout, modem status change and transmit overflow. Software clears sticky bits by writing ones to them. An interrupt mask changes only through a set register and a clear register. The single interrupt output is high whenever a sticky bit and its mask bit are both set.

Software reaches the unit through a small word-addressed register port. Writes take effect on the clock edge and reads are combinational.

Top module: `uart_irq_status`

## Requirements
- R1: Live status word (address 4) bit 0 is 1 exactly when the RX count is greater than or equal to the RX trigger level. Bit 13 is 1 exactly when the TX count is greater than or equal to the TX trigger level.
- R2: Live bits 1, 2, 3 and 4 are, in that order, RX count zero, RX count equal to DEPTH (64 by default), TX count zero and TX count equal to DEPTH.
- R3: On every clock edge, live bits 4:0 are ORed into sticky bits 4:0, and live bit 13 is ORed into sticky bit 10.
- R4: A one-cycle event pulse sets a sticky bit on the next edge: RX overrun bit 5, framing bit 6, parity bit 7, timeout bit 8, modem status bit 9, TX overflow bit 12. Sticky bit 11 is always 0.
- R5: Writing the sticky register (address 3) clears each bit written as 1 on that edge, unless the bit is set again in that same cycle.
- R6: When a set source (event or live flag) and a clearing write hit the same sticky bit in one cycle, the bit ends up 1.
- R7: Writing the mask-set register (address 0) ORs write data bits 12:0 into the 13-bit mask.
- R8: Writing the mask-clear register (address 1) clears the mask bits written as 1.
- R9: Writes to the mask address (address 2) leave the mask unchanged. Reading address 2 returns the mask.
- R10: irq_o is 1 exactly when the bitwise AND of the mask and the sticky register is nonzero.
- R11: During reset the mask and sticky registers read 0, both trigger levels read 32, and irq_o is 0.
- R12: Writing address 5 or 6 loads the RX or TX trigger level from the low CNT_W bits of the write data. Reading the same address returns the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_count_i | input | CNT_W | RX FIFO occupancy |
| tx_count_i | input | CNT_W | TX FIFO occupancy |
| ev_rx_ovr_i | input | 1 | RX overrun pulse |
| ev_frame_i | input | 1 | Framing error pulse |
| ev_parity_i | input | 1 | Parity error pulse |
| ev_timeout_i | input | 1 | Receive timeout pulse |
| ev_modem_i | input | 1 | Modem status change pulse |
| ev_tx_ovr_i | input | 1 | TX overflow pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle the edge-by-edge behaviour of the two registers:
- an event or live flag is present in the sticky register one edge later;
- a clear with no competing set empties the bit;
- set and clear writes move the mask as written, and direct mask writes leave it unchanged;
- trigger writes load the written level;
- RX empty and RX full are never reported together.

Only the bench scenarios show that the comparator thresholds are exact. It sweeps every count against several trigger levels, including 0 and DEPTH. The bench also shows the event-to-bit mapping, the interrupt gating for each event through mask set and clear, and the reset values seen through the read port.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int DW       = 32;
  localparam int STICKY_W = 13;

  // live status bit positions
  localparam int LV_RX_TRIG  = 0;
  localparam int LV_RX_EMPTY = 1;
  localparam int LV_RX_FULL  = 2;
  localparam int LV_TX_EMPTY = 3;
  localparam int LV_TX_FULL  = 4;
  localparam int LV_TX_TRIG  = 13;

  // sticky bit positions
  localparam int ST_RX_OVR  = 5;
  localparam int ST_FRAME   = 6;
  localparam int ST_PARITY  = 7;
  localparam int ST_TIMEOUT = 8;
  localparam int ST_MODEM   = 9;
  localparam int ST_TX_TRIG = 10;
  localparam int ST_TX_OVR  = 12;

  localparam int TRIG_RST = 32;

  typedef enum logic [2:0] {
    A_MASK_SET = 3'd0,
    A_MASK_CLR = 3'd1,
    A_MASK     = 3'd2,
    A_STICKY   = 3'd3,
    A_LIVE     = 3'd4,
    A_RX_TRIG  = 3'd5,
    A_TX_TRIG  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/uirq_live.sv
module uirq_live
  import uirq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  output logic [DW-1:0]    live_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam int NDIR = 2;  // 0: rx, 1: tx

  logic [NDIR-1:0][CNT_W-1:0] cnt, trig;
  logic [NDIR-1:0] hit, empty, full;

  assign cnt  = {tx_cnt_i, rx_cnt_i};
  assign trig = {tx_trig_i, rx_trig_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign hit[d]   = cnt[d] >= trig[d];
    assign empty[d] = cnt[d] == '0;
    assign full[d]  = cnt[d] == FULL_CNT;
  end

  always_comb begin
    live_o              = '0;
    live_o[LV_RX_TRIG]  = hit[0];
    live_o[LV_RX_EMPTY] = empty[0];
    live_o[LV_RX_FULL]  = full[0];
    live_o[LV_TX_EMPTY] = empty[1];
    live_o[LV_TX_FULL]  = full[1];
    live_o[LV_TX_TRIG]  = hit[1];
  end

  // R2: empty and full exclusive for a nonzero depth
  always_comb begin
    a_r2_rx_empty_full_excl: assert (!(live_o[LV_RX_EMPTY] && live_o[LV_RX_FULL]));
  end
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end

  assign q_o = q;

  for (genvar k = 0; k < W; k++) begin : g_chk
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q[k]);
    a_r5_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q[k]);
  end
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
  parameter int W = 13
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (set_we_i) q <= q | wdata_i;
    else if (clr_we_i) q <= q & ~wdata_i;
  end

  assign q_o = q;

  a_r7_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((q & $past(wdata_i)) == $past(wdata_i)));
  a_r8_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && !set_we_i) |=> ((q & $past(wdata_i)) == '0));
endmodule

// File: rtl/uirq_level.sv
module uirq_level #(
  parameter int CNT_W = 7,
  parameter int RST_V = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= CNT_W'(RST_V);
    else if (we_i) q_o <= wdata_i;
  end

  a_r12_level_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (q_o == $past(wdata_i)));
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic             ev_rx_ovr_i,
  input  logic             ev_frame_i,
  input  logic             ev_parity_i,
  input  logic             ev_timeout_i,
  input  logic             ev_modem_i,
  input  logic             ev_tx_ovr_i,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o
);
  localparam int SW = STICKY_W;

  logic [CNT_W-1:0] rx_trig, tx_trig;
  logic [DW-1:0]    live;
  logic [SW-1:0]    sticky, mask, st_set, st_clr;
  logic we_mset, we_mclr, we_st, we_rxt, we_txt;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  assign we_mset = reg_we_i && (reg_addr_i == A_MASK_SET);
  assign we_mclr = reg_we_i && (reg_addr_i == A_MASK_CLR);
  assign we_st   = reg_we_i && (reg_addr_i == A_STICKY);
  assign we_rxt  = reg_we_i && (reg_addr_i == A_RX_TRIG);
  assign we_txt  = reg_we_i && (reg_addr_i == A_TX_TRIG);

  uirq_level #(.CNT_W(CNT_W), .RST_V(TRIG_RST)) u_rx_level (
    .clk_i, .rst_ni, .we_i(we_rxt), .wdata_i(reg_wdata_i[CNT_W-1:0]), .q_o(rx_trig));

  uirq_level #(.CNT_W(CNT_W), .RST_V(TRIG_RST)) u_tx_level (
    .clk_i, .rst_ni, .we_i(we_txt), .wdata_i(reg_wdata_i[CNT_W-1:0]), .q_o(tx_trig));

  uirq_live #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_live (
    .rx_cnt_i(rx_count_i), .tx_cnt_i(tx_count_i),
    .rx_trig_i(rx_trig), .tx_trig_i(tx_trig), .live_o(live));

  always_comb begin
    st_set             = '0;
    st_set[4:0]        = live[4:0];
    st_set[ST_TX_TRIG] = live[LV_TX_TRIG];
    st_set[ST_RX_OVR]  = ev_rx_ovr_i;
    st_set[ST_FRAME]   = ev_frame_i;
    st_set[ST_PARITY]  = ev_parity_i;
    st_set[ST_TIMEOUT] = ev_timeout_i;
    st_set[ST_MODEM]   = ev_modem_i;
    st_set[ST_TX_OVR]  = ev_tx_ovr_i;
  end

  assign st_clr = we_st ? reg_wdata_i[SW-1:0] : '0;

  uirq_sticky #(.W(SW)) u_sticky (
    .clk_i, .rst_ni, .set_i(st_set), .clr_i(st_clr), .q_o(sticky));

  uirq_mask #(.W(SW)) u_mask (
    .clk_i, .rst_ni, .set_we_i(we_mset), .clr_we_i(we_mclr),
    .wdata_i(reg_wdata_i[SW-1:0]), .q_o(mask));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_MASK:    reg_rdata_o[SW-1:0]    = mask;
      A_STICKY:  reg_rdata_o[SW-1:0]    = sticky;
      A_LIVE:    reg_rdata_o            = live;
      A_RX_TRIG: reg_rdata_o[CNT_W-1:0] = rx_trig;
      A_TX_TRIG: reg_rdata_o[CNT_W-1:0] = tx_trig;
      default:   reg_rdata_o            = '0;
    endcase
  end

  assign irq_o = |(mask & sticky);

  a_r9_mask_direct_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_MASK) |=> $stable(mask));
  a_r10_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  a_r3_tx_trig_folds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live[LV_TX_TRIG] |=> sticky[ST_TX_TRIG]);
  a_r4_bit11_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sticky[11]);
endmodule

// File: tb/sim_uart_irq_status.sv
module sim_uart_irq_status;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [CNT_W-1:0] rx_cnt = '0, tx_cnt = '0;
  logic [5:0] ev = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  uart_irq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk_i, .rst_ni, .rx_count_i(rx_cnt), .tx_count_i(tx_cnt),
    .ev_rx_ovr_i(ev[0]), .ev_frame_i(ev[1]), .ev_parity_i(ev[2]),
    .ev_timeout_i(ev[3]), .ev_modem_i(ev[4]), .ev_tx_ovr_i(ev[5]),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk_i);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk_i);
    ev[k] = 1'b1;
    @(posedge clk_i);
    #1;
    ev = '0;
  endtask

  function automatic logic [31:0] exp_live(int rc, int tc, int rt, int tt);
    logic [31:0] v = '0;
    v[0]  = rc >= rt;
    v[1]  = rc == 0;
    v[2]  = rc == DEPTH;
    v[3]  = tc == 0;
    v[4]  = tc == DEPTH;
    v[13] = tc >= tt;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int pos[6] = '{5, 6, 7, 8, 9, 12};
    int levels[5] = '{0, 1, 32, 63, 64};

    // R11 reset state
    repeat (3) @(negedge clk_i);
    rd(3'd3, d); chk("R11 sticky reset", d, 32'h0);
    rd(3'd2, d); chk("R11 mask reset", d, 32'h0);
    rd(3'd5, d); chk("R11 rx trig reset", d, 32'd32);
    rd(3'd6, d); chk("R11 tx trig reset", d, 32'd32);
    chk("R11 irq reset", {31'b0, irq}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    rd(3'd3, d); chk("R3 empty flags folded", d, 32'h0000_000A);

    // R1 R2 R12 sweep over counts and levels
    foreach (levels[i]) begin
      wr(3'd5, levels[i]); rd(3'd5, d); chk("R12 rx level", d, levels[i]);
      wr(3'd6, levels[i]); rd(3'd6, d); chk("R12 tx level", d, levels[i]);
      for (int c = 0; c <= DEPTH; c++) begin
        @(negedge clk_i); rx_cnt = c; tx_cnt = 7'd5;
        rd(3'd4, d); chk("R1 R2 rx sweep", d, exp_live(c, 5, levels[i], levels[i]));
        @(negedge clk_i); rx_cnt = 7'd3; tx_cnt = c;
        rd(3'd4, d); chk("R1 R2 tx sweep", d, exp_live(3, c, levels[i], levels[i]));
      end
    end
    wr(3'd5, 32); wr(3'd6, 32);

    // R3 R6 live flags re-set through a full clear
    @(negedge clk_i); rx_cnt = 7'd64; tx_cnt = 7'd64;
    wr(3'd3, 32'h1FFF);
    rd(3'd3, d); chk("R3 full and trig fold", d, 32'h0000_0415);
    @(negedge clk_i); rx_cnt = 7'd10; tx_cnt = 7'd10;
    wr(3'd3, 32'h1FFF);
    rd(3'd3, d); chk("R5 clear all", d, 32'h0);

    // R4 R5 R7 R8 R9 R10 per event
    foreach (pos[i]) begin
      pulse(i);
      rd(3'd3, d); chk("R4 event bit", d, 32'h1 << pos[i]);
      chk("R10 irq masked", {31'b0, irq}, 32'h0);
      wr(3'd0, 32'h1 << pos[i]);
      chk("R10 irq unmasked", {31'b0, irq}, 32'h1);
      wr(3'd2, 32'h0);
      rd(3'd2, d); chk("R9 direct mask write", d, 32'h1 << pos[i]);
      chk("R9 irq kept", {31'b0, irq}, 32'h1);
      wr(3'd1, 32'h1 << pos[i]);
      rd(3'd2, d); chk("R8 mask cleared", d, 32'h0);
      chk("R10 irq after clear", {31'b0, irq}, 32'h0);
      wr(3'd3, 32'h1 << pos[i]);
      rd(3'd3, d); chk("R5 w1c", d, 32'h0);
    end

    // R6 event beats same-cycle clear
    pulse(1);
    @(negedge clk_i);
    ev[1] = 1'b1; reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h40;
    @(posedge clk_i); #1;
    ev = '0; reg_we = 1'b0;
    rd(3'd3, d); chk("R6 set wins", d, 32'h40);
    wr(3'd3, 32'h40);
    rd(3'd3, d); chk("R5 cleared after", d, 32'h0);

    // R7 R8 mask sweep
    for (int b = 0; b < 13; b++) begin
      wr(3'd0, 32'h1 << b);
      rd(3'd2, d); chk("R7 mask accumulate", d, (32'h1 << (b + 1)) - 1);
    end
    for (int b = 0; b < 13; b++) begin
      wr(3'd1, 32'h1 << b);
      rd(3'd2, d); chk("R8 mask remove", d, 32'h1FFF & ~((32'h1 << (b + 1)) - 1));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule